// File: doc/BRIEF.md
# Codec Serial Frame Port with Control Register Access

This block is the device end of a 16-bit synchronous serial link between a host and a converter codec. The link has one line from the host (`sdi`), one line to the host (`sdo`) and a frame sync (`fs`). The block clock is the shift clock, so one bit moves in each direction on every clock. Words go most significant bit first. `fs` is high in the cycle that carries bit 15 of a word.

In a primary frame, the host sends a 14-bit DAC sample, a level for a dedicated digital output and a flag that requests a secondary frame. In the same frame the device returns a 14-bit ADC sample and the state of two general-purpose pins. A requested secondary frame uses the next frame slot and reads or writes one 8-bit control register, chosen by a 5-bit address. In a read, the device looks up the register as soon as the address bits have arrived and sends the contents in the low byte of the same frame. After the secondary frame, primary frames resume.

Samples cross the block boundary as streams. The ADC side is valid/ready: `adc_ready` is high only in the `fs` cycle of a primary frame, and the sample is taken in that cycle. If `adc_valid` is low at that moment, zeros go out and no sample is consumed. The DAC side cannot be back-pressured because the serial line runs at a fixed rate, so `dac_valid` is a one-cycle strobe that has no ready.

Top module: `codec_serial_port`

## Requirements
- R1: Bits move MSB first, one per clock. In the `fs` cycle, `sdo` carries bit 15 and `sdi` is taken as bit 15. When no word is in progress, `sdo` is 0. After reset, `dac_valid`, `gpo` and `sdo` are 0.
- R2: For a primary frame, `dac_data` takes inbound bits 15:2, and `dac_valid` pulses high for one cycle, the cycle after the clock that carried bit 0.
- R3: `gpo` takes inbound bit 1 of each primary frame and holds that level until the next primary frame completes.
- R4: A primary frame whose inbound bit 0 is 1 makes the next frame a secondary frame. If bit 0 is 0, the next frame is primary. The frame after a secondary frame is always primary.
- R5: In a primary frame, outbound bits 15:2 carry `adc_data` when `adc_valid` is high in the `fs` cycle, and zeros otherwise. `adc_ready` is high only in the `fs` cycle of a primary frame.
- R6: Outbound bit i (i = 0, 1) of a primary frame equals `gpio_in[i]` when bit i of register 0 (report enable) is 1 and bit i of register 1 (1 = pin is an output) is 0. Otherwise the bit is 0.
- R7: In a secondary frame, inbound bit 15 = 1 selects a read and bits 14:10 give the address. A read returns the register in outbound bits 7:0 with bits 15:8 zero. Inbound bits 7:0 of a read are ignored.
- R8: A secondary write (bit 15 = 0) stores inbound bits 7:0 in the addressed register when the frame completes. The whole outbound word of a write is zero.
- R9: Only addresses 0 to NUM_REGS-1 exist. A write to any other address changes no register, and a read of one returns zeros.
- R10: `cfg_regs` shows register n in bits 8n+7:8n. All registers reset to 0.
- R11: An `fs` pulse in the middle of a word discards the partial word: it produces no DAC strobe, no `gpo` change, no write and no secondary request, and a new word starts at bit 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; one serial bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| fs | input | 1 | Frame sync, high on bit 15 of a word |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| dac_data | output | 14 | DAC sample from the last primary frame |
| dac_valid | output | 1 | One-cycle strobe for `dac_data` |
| gpo | output | 1 | Dedicated digital output level |
| adc_data | input | 14 | ADC sample offered to the port |
| adc_valid | input | 1 | `adc_data` is valid |
| adc_ready | output | 1 | Sample taken this cycle |
| gpio_in | input | 2 | Levels of the two general-purpose pins |
| cfg_regs | output | 8*NUM_REGS | Flattened control register contents |

## Verification
On every cycle the assertions check the following: `dac_valid` is a single-cycle strobe that only follows the completion of a primary word; `gpo` changes only with that strobe; `adc_ready` appears only together with `fs`; register contents change only at the end of a secondary frame; and `sdo` stays low between words. The exact bit layout of outbound words is shown only by the bench scenarios. So are the scheduling of secondary frames by the request flag, the read-back of written values, the masking of the general-purpose pins, the handling of unimplemented addresses and the discarding of a word cut short by an early `fs`.

// File: rtl/csp_pkg.sv
`timescale 1ns/1ps
package csp_pkg;
  localparam int WORD_W    = 16;
  localparam int SAMPLE_W  = 14;
  localparam int CTRL_W    = WORD_W - SAMPLE_W;
  localparam int ADDR_W    = 5;
  localparam int REG_W     = 8;
  localparam int ADDR_LSB  = 10;
  localparam int RW_BIT    = WORD_W - 1;
  localparam int HEAD_W    = ADDR_W + 1;
  localparam int REPLY_IDX = WORD_W - ADDR_LSB;
  localparam int CNT_W     = $clog2(WORD_W) + 1;
  localparam logic [CNT_W-1:0] IDLE_IDX = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);
endpackage

// File: rtl/csp_bitseq.sv
`timescale 1ns/1ps
module csp_bitseq
  import csp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs,
  input  logic              sdi,
  output logic [CNT_W-1:0]  cur_idx,
  output logic              active,
  output logic              word_done,
  output logic [WORD_W-1:0] rx_word,
  output logic [HEAD_W-1:0] rx_head
);
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] shift_q;

  always_comb begin
    cur_idx   = fs ? '0 : cnt_q;
    active    = fs || (cnt_q != IDLE_IDX);
    word_done = active && (cur_idx == LAST_IDX);
    rx_word   = {shift_q[WORD_W-2:0], sdi};
    rx_head   = shift_q[HEAD_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= IDLE_IDX;
      shift_q <= '0;
    end else begin
      if (fs)                     cnt_q <= CNT_W'(1);
      else if (cnt_q != IDLE_IDX) cnt_q <= cnt_q + CNT_W'(1);
      if (active) shift_q <= {shift_q[WORD_W-2:0], sdi};
    end
  end
endmodule

// File: rtl/csp_tx.sv
`timescale 1ns/1ps
module csp_tx
  import csp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs,
  input  logic              active,
  input  logic [WORD_W-1:0] load_word,
  input  logic              reply_load,
  input  logic [REG_W-1:0]  reply,
  output logic              sdo
);
  logic [WORD_W-1:0] tx_q;
  logic [WORD_W-1:0] tx_next;

  always_comb begin
    tx_next = {tx_q[WORD_W-2:0], 1'b0};
    if (reply_load) tx_next[REPLY_IDX+1 +: REG_W] = reply;
    sdo = fs ? load_word[WORD_W-1] : (active & tx_q[WORD_W-1]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  tx_q <= '0;
    else if (fs) tx_q <= {load_word[WORD_W-2:0], 1'b0};
    else         tx_q <= tx_next;
  end
endmodule

// File: rtl/csp_regfile.sv
`timescale 1ns/1ps
module csp_regfile
  import csp_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         waddr,
  input  logic [REG_W-1:0]          wdata,
  input  logic [ADDR_W-1:0]         raddr,
  output logic [REG_W-1:0]          rdata,
  output logic [NUM_REGS*REG_W-1:0] regs_flat
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [REG_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                             q <= '0;
      else if (we && waddr == ADDR_W'(i))     q <= wdata;
    end
    assign regs_flat[i*REG_W +: REG_W] = q;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (raddr == ADDR_W'(i)) rdata = regs_flat[i*REG_W +: REG_W];
  end
endmodule

// File: rtl/codec_serial_port.sv
`timescale 1ns/1ps
module codec_serial_port
  import csp_pkg::*;
#(
  parameter int NUM_REGS  = 8,
  parameter int MODE_ADDR = 0,
  parameter int DIR_ADDR  = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fs,
  input  logic                      sdi,
  output logic                      sdo,
  output logic [SAMPLE_W-1:0]       dac_data,
  output logic                      dac_valid,
  output logic                      gpo,
  input  logic [SAMPLE_W-1:0]       adc_data,
  input  logic                      adc_valid,
  output logic                      adc_ready,
  input  logic [CTRL_W-1:0]         gpio_in,
  output logic [NUM_REGS*REG_W-1:0] cfg_regs
);
  logic [CNT_W-1:0]  cur_idx;
  logic              active, word_done;
  logic [WORD_W-1:0] rx_word;
  logic [HEAD_W-1:0] rx_head;
  logic              sec_pending, sec_frame, cur_sec;
  logic              reg_we, reply_load;
  logic [REG_W-1:0]  rdata, reply;
  logic [CTRL_W-1:0] pin_bits, mode_bits, dir_bits;
  logic [SAMPLE_W-1:0] adc_take;
  logic [WORD_W-1:0] load_word;

  csp_bitseq u_seq (
    .clk(clk), .rst_n(rst_n), .fs(fs), .sdi(sdi),
    .cur_idx(cur_idx), .active(active), .word_done(word_done),
    .rx_word(rx_word), .rx_head(rx_head)
  );

  // frame kind: the fs cycle already belongs to the new frame
  assign cur_sec = fs ? sec_pending : sec_frame;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_pending <= 1'b0;
      sec_frame   <= 1'b0;
    end else if (fs) begin
      sec_frame   <= sec_pending;
      sec_pending <= 1'b0;
    end else if (word_done && !cur_sec) begin
      sec_pending <= rx_word[0];
    end
  end

  // primary inbound decode
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dac_valid <= 1'b0;
      dac_data  <= '0;
      gpo       <= 1'b0;
    end else begin
      dac_valid <= word_done && !cur_sec;
      if (word_done && !cur_sec) begin
        dac_data <= rx_word[WORD_W-1:CTRL_W];
        gpo      <= rx_word[1];
      end
    end
  end

  // secondary access: write at word end, read once the address is in
  assign reg_we     = word_done && cur_sec && !rx_word[RW_BIT];
  assign reply_load = active && cur_sec && (cur_idx == CNT_W'(REPLY_IDX));
  assign reply      = rx_head[HEAD_W-1] ? rdata : '0;

  csp_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we),
    .waddr(rx_word[ADDR_LSB +: ADDR_W]), .wdata(rx_word[REG_W-1:0]),
    .raddr(rx_head[ADDR_W-1:0]), .rdata(rdata), .regs_flat(cfg_regs)
  );

  // primary outbound word
  assign mode_bits = cfg_regs[MODE_ADDR*REG_W +: CTRL_W];
  assign dir_bits  = cfg_regs[DIR_ADDR*REG_W +: CTRL_W];
  assign pin_bits  = gpio_in & mode_bits & ~dir_bits;
  assign adc_ready = fs && !sec_pending;
  assign adc_take  = (adc_ready && adc_valid) ? adc_data : '0;
  assign load_word = sec_pending ? '0 : {adc_take, pin_bits};

  csp_tx u_tx (
    .clk(clk), .rst_n(rst_n), .fs(fs), .active(active),
    .load_word(load_word), .reply_load(reply_load), .reply(reply), .sdo(sdo)
  );
endmodule

// File: rtl/csp_checker.sv
`timescale 1ns/1ps
module csp_checker
  import csp_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      fs,
  input logic                      sdo,
  input logic                      dac_valid,
  input logic                      gpo,
  input logic                      adc_ready,
  input logic [NUM_REGS*REG_W-1:0] cfg_regs,
  input logic [CNT_W-1:0]          cur_idx,
  input logic                      word_done,
  input logic                      cur_sec
);
  // R2: strobe lasts one cycle
  a_r2_dac_single: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid |=> !dac_valid);
  // R2: strobe only after a completed primary word
  a_r2_dac_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid |-> $past(word_done && !cur_sec));
  // R3: output level moves only with a primary completion
  a_r3_gpo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gpo) |-> dac_valid);
  // R5: sample taken only on a frame sync
  a_r5_ready_on_fs: assert property (@(posedge clk) disable iff (!rst_n)
    adc_ready |-> fs);
  // R8: registers change only at the end of a secondary frame
  a_r8_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_regs) |-> $past(word_done && cur_sec));
  // R1: line quiet between words
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!fs && cur_idx == IDLE_IDX) |-> !sdo);
endmodule

bind codec_serial_port csp_checker #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .fs(fs), .sdo(sdo), .dac_valid(dac_valid),
  .gpo(gpo), .adc_ready(adc_ready), .cfg_regs(cfg_regs),
  .cur_idx(cur_idx), .word_done(word_done), .cur_sec(cur_sec)
);

// File: tb/codec_serial_port_tb.sv
`timescale 1ns/1ps
module codec_serial_port_tb;
  localparam int NR = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fs = 1'b0, sdi = 1'b0;
  logic sdo, dac_valid, gpo, adc_ready;
  logic [13:0] dac_data;
  logic [13:0] adc_data = '0;
  logic adc_valid = 1'b0;
  logic [1:0] gpio_in = '0;
  logic [NR*8-1:0] cfg_regs;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [13:0] dac_q[$];
  logic [7:0] m_regs [NR];

  always #2.5 clk = ~clk;

  codec_serial_port #(.NUM_REGS(NR)) u_dut (
    .clk(clk), .rst_n(rst_n), .fs(fs), .sdi(sdi), .sdo(sdo),
    .dac_data(dac_data), .dac_valid(dac_valid), .gpo(gpo),
    .adc_data(adc_data), .adc_valid(adc_valid), .adc_ready(adc_ready),
    .gpio_in(gpio_in), .cfg_regs(cfg_regs)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // monitor: DAC scoreboard (R2)
  always @(negedge clk) begin
    if (rst_n && dac_valid) begin
      if (dac_q.size() == 0) chk(0, "R2 unexpected dac strobe", {50'b0, dac_data}, 0);
      else begin
        logic [13:0] e;
        e = dac_q.pop_front();
        chk(dac_data == e, "R2 dac sample", {50'b0, dac_data}, {50'b0, e});
      end
    end
  end

  function automatic logic [1:0] pins_exp();
    return gpio_in & m_regs[0][1:0] & ~m_regs[1][1:0];
  endfunction

  task automatic xfer(input logic [15:0] w, input logic [15:0] exp, input bit exp_rdy,
                      input bit prim, input string tag);
    logic [15:0] got;
    got = '0;
    if (prim) dac_q.push_back(w[15:2]);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      fs  = (k == 0);
      sdi = w[15-k];
      #1;
      got[15-k] = sdo;
      if (k == 0) chk(adc_ready == exp_rdy, {tag, " R5/R4 adc_ready"}, {63'b0, adc_ready}, {63'b0, exp_rdy});
    end
    chk(got == exp, tag, {48'b0, got}, {48'b0, exp});
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      fs = 0; sdi = 0;
      #1;
      chk(sdo == 1'b0, "R1 idle sdo", {63'b0, sdo}, 0);
    end
  endtask

  task automatic sec_write(input logic [4:0] a, input logic [7:0] d, input string tag);
    xfer({1'b0, a, 2'b00, d}, 16'h0000, 0, 0, tag);
    if (a < NR) m_regs[a] = d;
    idle(1);
  endtask

  task automatic sec_read(input logic [4:0] a, input string tag);
    logic [7:0] e;
    e = (a < NR) ? m_regs[a] : 8'h00;
    xfer({1'b1, a, 10'h3FF}, {8'h00, e}, 0, 0, tag);
    idle(1);
  endtask

  task automatic prim(input logic [13:0] dac, input bit g, input bit req, input string tag);
    logic [15:0] e;
    e = {(adc_valid ? adc_data : 14'h0), pins_exp()};
    xfer({dac, g, req}, e, 1, 1, tag);
    idle(1);
    chk(gpo == g, "R3 gpo follows bit 1", {63'b0, gpo}, {63'b0, g});
  endtask

  initial begin
    for (int i = 0; i < NR; i++) m_regs[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(sdo == 0 && dac_valid == 0 && gpo == 0, "R1 reset outputs", {61'b0, sdo, dac_valid, gpo}, 0);
    chk(cfg_regs == '0, "R10 reset registers", cfg_regs, 0);
    rst_n = 1;
    idle(2);

    adc_valid = 1; adc_data = 14'h1234;
    prim(14'h2AF3, 0, 0, "R2 R5 primary basic");
    adc_data = 14'h0F0F;
    prim(14'h1555, 1, 1, "R4 primary with request");
    sec_write(5'd0, 8'h03, "R8 write mode reg");
    chk(cfg_regs[7:0] == 8'h03, "R10 R8 mode reg value", {56'b0, cfg_regs[7:0]}, 8'h03);

    gpio_in = 2'b11; adc_data = 14'h3FFF;
    prim(14'h0001, 1, 1, "R6 both pins reported");
    sec_write(5'd1, 8'h01, "R8 write dir reg");
    adc_valid = 0;
    prim(14'h3FFF, 0, 1, "R6 R5 pin0 output masked, adc invalid zeros");
    adc_valid = 1; adc_data = 14'h2222;
    sec_read(5'd1, "R7 read dir reg");

    prim(14'h0ABC, 1, 0, "R4 no request");
    prim(14'h0DEF, 0, 0, "R4 stays primary");

    prim(14'h0100, 0, 1, "R4 req bad write");
    sec_write(5'd20, 8'hFF, "R9 write unimplemented reply");
    chk(cfg_regs == {48'b0, 8'h01, 8'h03}, "R9 write ignored", cfg_regs, {48'b0, 8'h01, 8'h03});
    prim(14'h0200, 0, 1, "R4 req bad read");
    sec_read(5'd20, "R9 read unimplemented");

    prim(14'h0300, 1, 1, "R4 req top write");
    sec_write(5'd7, 8'hA5, "R8 write top reg");
    chk(cfg_regs[63:56] == 8'hA5, "R10 top reg field", {56'b0, cfg_regs[63:56]}, 8'hA5);
    prim(14'h0400, 1, 1, "R4 req top read");
    sec_read(5'd7, "R7 read top reg");

    // R11: partial word then restart
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      fs = (k == 0); sdi = 1'b1;
    end
    gpio_in = 2'b00;
    prim(14'h1234, 0, 0, "R11 restart primary");
    prim(14'h0777, 0, 0, "R11 no secondary after cut word");
    idle(4);
    chk(dac_q.size() == 0, "R11 R2 dac queue drained", dac_q.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule